// File: doc/BRIEF.md
# Downstream ATM Cell Address Filter and Queue Dispatcher

This block sits after the downstream error-correction stage of a cable return-channel receiver. Cells arrive one byte per accepted cycle, 53 bytes each. The first byte carries a start strobe and a flag that says whether the codeword decoded cleanly. The block reads the virtual path and channel identifiers from the cell header. It compares them with a small programmed table. Each kept cell is sent whole to one of two write ports: one feeds a queue of MAC management messages, the other a queue of application-layer data.

A cell goes to the MAC queue when its identifiers equal the programmed MAC channel and its 16-bit destination field equals the station address. A cell goes to the application queue when it matches one of four enabled identifier entries. Every other cell is dropped, and so is every cell flagged as damaged. The route is only known once the header and the destination field have arrived. The block therefore keeps the cell's bytes in a short replay buffer and writes the cell out in order from its first byte. When a target queue reports that it cannot hold one more full cell, the cell is dropped and that queue's overflow counter goes up by one.

Top module: `atm_cell_filter`

## Requirements
- R1: A cell is 53 consecutive accepted bytes. The first byte has `in_sop` high with `in_valid`. `in_ok` is sampled with that first byte. A cell whose `in_ok` is low causes no write on either port and no counter change.
- R2: The match key is taken from the first four bytes, most significant bit first: VPI is byte0[3:0] followed by byte1[7:4], and VCI is byte1[3:0], byte2 and byte3[7:4]. The destination field is bytes 5 and 6, byte 5 being the upper half. Bits 7:4 of byte0 and bits 3:0 of byte3, as well as byte 4, play no part.
- R3: A write on the configuration port takes effect when `cfg_we` is high. Addresses 0 to 3 hold the application entries and address 4 holds the MAC channel. Each of these takes the word {enable[24], VPI[23:16], VCI[15:0]}. Address 5 takes the station address in bits 15:0. Addresses 6 and 7 change nothing. After reset every entry is disabled.
- R4: A cell whose key equals the enabled MAC channel and whose destination equals the station address is written to the MAC port. All 53 bytes are written in arrival order, with `mac_wr_sop` high on the first byte only.
- R5: A cell on the MAC channel whose destination differs from the station address is dropped. This holds even when an application entry carries the same key.
- R6: A cell that is not on the MAC channel and matches any enabled application entry is written whole and in order to the application port, with `app_wr_sop` on its first byte.
- R7: An entry whose enable bit is clear never matches.
- R8: A cell matching nothing produces no write and leaves both overflow counters unchanged.
- R9: The almost-full input of the target queue is sampled when the seventh byte of the cell is accepted. If that input is high, the whole cell is dropped and that queue's 8-bit overflow counter adds one, saturating at 255. The other queue is not affected.
- R10: Idle cycles may appear anywhere inside or between cells. Bytes without `in_sop` that arrive outside a cell are ignored. Cells may follow one another with no idle cycle between them.
- R11: During reset and right after it, neither write enable is high and both overflow counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte strobe |
| in_sop | input | 1 | First byte of a cell |
| in_ok | input | 1 | Cell decoded without error, sampled with `in_sop` |
| in_data | input | 8 | Input byte |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 3 | Table write address |
| cfg_wdata | input | 25 | Table write word |
| mac_full | input | 1 | MAC queue cannot take another full cell |
| mac_wr_en | output | 1 | MAC queue write strobe |
| mac_wr_sop | output | 1 | First byte of a cell on the MAC port |
| mac_wr_data | output | 8 | MAC queue write byte |
| mac_ovf_cnt | output | 8 | Cells dropped because the MAC queue was full |
| app_full | input | 1 | Application queue cannot take another full cell |
| app_wr_en | output | 1 | Application queue write strobe |
| app_wr_sop | output | 1 | First byte of a cell on the application port |
| app_wr_data | output | 8 | Application queue write byte |
| app_ovf_cnt | output | 8 | Cells dropped because the application queue was full |

## Verification
The bench sweeps every kind of cell: each application entry (one of them disabled), the MAC channel with a matching and a wrong destination, a key that differs from a live entry by one bit, and a damaged cell. It runs them one at a time and also back to back under several idle-cycle patterns. A design that mixed up the nibble split of VPI and VCI, or let the application table win over the MAC channel, would place cells on the wrong port. A design that reused a route across adjacent cells would write bytes of one cell under the route of another. The bench also injects stray non-start bytes, rewrites entries, and pushes more than 255 cells into a full queue. A missing saturation would wrap the counter to zero, and a wrong sampling point for the full flag would drop cells on the queue that has room.

// File: rtl/atm_flt_pkg.sv
package atm_flt_pkg;

  localparam int CELL_BYTES = 53;
  localparam int HDR_BYTES  = 5;
  localparam int KEY_W      = 24;
  localparam int CFG_DW     = KEY_W + 1;

  typedef enum logic [1:0] {
    RT_PEND = 2'd0,
    RT_MAC  = 2'd1,
    RT_APP  = 2'd2,
    RT_DROP = 2'd3
  } route_e;

  typedef struct packed {
    logic       sop;
    logic       cid;
    logic [7:0] data;
  } ent_t;

endpackage

// File: rtl/atm_cell_tracker.sv
module atm_cell_tracker
  import atm_flt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_ok,
  input  logic [7:0]        in_data,
  output logic              acc,
  output logic              cid,
  output logic              decide,
  output logic [KEY_W-1:0]  key,
  output logic [ADDR_W-1:0] dst
);

  localparam int HOLD  = HDR_BYTES + ADDR_W / 8;
  localparam int IDX_W = $clog2(CELL_BYTES);
  localparam int DQ_W  = ADDR_W - 8;
  localparam logic [IDX_W-1:0] I1       = IDX_W'(1);
  localparam logic [IDX_W-1:0] I2       = IDX_W'(2);
  localparam logic [IDX_W-1:0] I3       = IDX_W'(3);
  localparam logic [IDX_W-1:0] DST_LO   = IDX_W'(HDR_BYTES);
  localparam logic [IDX_W-1:0] DEC_IDX  = IDX_W'(HOLD - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

  logic             live_q, live_d;
  logic             cid_q, cid_d;
  logic [IDX_W-1:0] idx_q, idx_d, cur_idx;
  logic [KEY_W-1:0] key_q, key_d;
  logic [DQ_W-1:0]  dst_q, dst_d;

  always_comb begin
    cur_idx = in_sop ? '0 : idx_q;
    acc     = in_valid && (in_sop ? in_ok : live_q);
    cid     = in_sop ? ~cid_q : cid_q;
    decide  = acc && (cur_idx == DEC_IDX);
    key     = key_q;
    dst     = {dst_q, in_data};
  end

  always_comb begin
    live_d = live_q;
    cid_d  = cid_q;
    idx_d  = idx_q;
    key_d  = key_q;
    dst_d  = dst_q;
    if (in_valid && in_sop && !in_ok) begin
      live_d = 1'b0;
    end
    if (acc) begin
      idx_d  = cur_idx + I1;
      cid_d  = cid;
      live_d = (cur_idx != LAST_IDX);
      if (cur_idx == '0) key_d[23:20] = in_data[3:0];
      if (cur_idx == I1) key_d[19:12] = in_data;
      if (cur_idx == I2) key_d[11:4]  = in_data;
      if (cur_idx == I3) key_d[3:0]   = in_data[7:4];
      if (cur_idx >= DST_LO && cur_idx < DEC_IDX) begin
        dst_d = DQ_W'({dst_q, in_data});
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      cid_q  <= 1'b0;
      idx_q  <= '0;
      key_q  <= '0;
      dst_q  <= '0;
    end else begin
      live_q <= live_d;
      cid_q  <= cid_d;
      idx_q  <= idx_d;
      key_q  <= key_d;
      dst_q  <= dst_d;
    end
  end

  // R1: an open cell always sits strictly inside its 53-byte window
  a_r1_live_window: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (idx_q != '0 && idx_q <= LAST_IDX));

endmodule

// File: rtl/atm_match_table.sv
module atm_match_table
  import atm_flt_pkg::*;
#(
  parameter int N_APP  = 4,
  parameter int ADDR_W = 16,
  parameter int CFG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic [KEY_W-1:0]  key,
  input  logic [ADDR_W-1:0] dst,
  output route_e            route
);

  localparam int N_ENT = N_APP + 1;
  localparam int EN_B  = KEY_W;

  logic [CFG_DW-1:0] ent_q [N_ENT];
  logic [CFG_DW-1:0] ent_d [N_ENT];
  logic [ADDR_W-1:0] sta_q, sta_d;
  logic [N_APP-1:0]  app_en, app_hit;
  logic              mac_ch;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    always_comb begin
      ent_d[i] = ent_q[i];
      if (cfg_we && cfg_addr == CFG_AW'(i)) ent_d[i] = cfg_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[i] <= '0;
      else        ent_q[i] <= ent_d[i];
    end
  end

  always_comb begin
    sta_d = sta_q;
    if (cfg_we && cfg_addr == CFG_AW'(N_ENT)) sta_d = cfg_wdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sta_q <= '0;
    else        sta_q <= sta_d;
  end

  for (genvar i = 0; i < N_APP; i++) begin : g_hit
    assign app_en[i]  = ent_q[i][EN_B];
    assign app_hit[i] = app_en[i] && (ent_q[i][KEY_W-1:0] == key);
  end

  always_comb begin
    mac_ch = ent_q[N_APP][EN_B] && (ent_q[N_APP][KEY_W-1:0] == key);
    if (mac_ch)        route = (dst == sta_q) ? RT_MAC : RT_DROP;
    else if (|app_hit) route = RT_APP;
    else               route = RT_DROP;
  end

  // R7: the application route needs at least one enabled entry
  a_r7_app_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (route == RT_APP) |-> (|app_en));

endmodule

// File: rtl/atm_replay_buf.sv
module atm_replay_buf
  import atm_flt_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  ent_t       push_ent,
  input  logic       set_pend,
  input  logic       pend_cid,
  input  logic       set_route,
  input  logic       route_cid,
  input  route_e     route_val,
  output logic       mac_wr_en,
  output logic       app_wr_en,
  output logic       wr_sop,
  output logic [7:0] wr_data
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  ent_t             mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  route_e           route_q [2];
  route_e           route_d [2];
  ent_t             head;
  route_e           head_rt;
  logic             pop;

  always_comb begin
    head      = mem_q[rd_ptr_q];
    head_rt   = route_q[head.cid];
    pop       = (count_q != '0) && (head_rt != RT_PEND);
    mac_wr_en = pop && (head_rt == RT_MAC);
    app_wr_en = pop && (head_rt == RT_APP);
    wr_sop    = head.sop;
    wr_data   = head.data;
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (push) wr_ptr_d = wr_ptr_q + PTR_W'(1);
    if (pop)  rd_ptr_d = rd_ptr_q + PTR_W'(1);
    if (push && !pop)      count_d = count_q + CNT_W'(1);
    else if (!push && pop) count_d = count_q - CNT_W'(1);
    route_d = route_q;
    if (set_pend)  route_d[pend_cid]  = RT_PEND;
    if (set_route) route_d[route_cid] = route_val;
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_ptr_q] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      count_q    <= '0;
      route_q[0] <= RT_DROP;
      route_q[1] <= RT_DROP;
    end else begin
      wr_ptr_q   <= wr_ptr_d;
      rd_ptr_q   <= rd_ptr_d;
      count_q    <= count_d;
      route_q[0] <= route_d[0];
      route_q[1] <= route_d[1];
    end
  end

  // R10: back-to-back cells and gaps never push into a full buffer
  a_r10_buf_room: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((count_q != CNT_W'(DEPTH)) || pop));

endmodule

// File: rtl/atm_cell_filter.sv
module atm_cell_filter
  import atm_flt_pkg::*;
#(
  parameter int N_APP     = 4,
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 8,
  parameter int BUF_DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic                         in_sop,
  input  logic                         in_ok,
  input  logic [7:0]                   in_data,
  input  logic                         cfg_we,
  input  logic [$clog2(N_APP+2)-1:0]   cfg_addr,
  input  logic [24:0]                  cfg_wdata,
  input  logic                         mac_full,
  output logic                         mac_wr_en,
  output logic                         mac_wr_sop,
  output logic [7:0]                   mac_wr_data,
  output logic [CNT_W-1:0]             mac_ovf_cnt,
  input  logic                         app_full,
  output logic                         app_wr_en,
  output logic                         app_wr_sop,
  output logic [7:0]                   app_wr_data,
  output logic [CNT_W-1:0]             app_ovf_cnt
);

  localparam int CFG_AW = $clog2(N_APP + 2);
  localparam int SEEN_W = $clog2(CELL_BYTES + 1);

  logic              acc, cid, decide;
  logic [KEY_W-1:0]  key;
  logic [ADDR_W-1:0] dst;
  route_e            raw_rt, final_rt;
  logic [1:0]        inc, full_v, wr_en_v;
  logic [CNT_W-1:0]  ovf_q [2];
  logic [CNT_W-1:0]  ovf_d [2];
  logic              wr_sop;
  logic [7:0]        wr_data;
  ent_t              push_ent;

  atm_cell_tracker #(.ADDR_W(ADDR_W)) u_track (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_ok(in_ok), .in_data(in_data), .acc(acc), .cid(cid),
    .decide(decide), .key(key), .dst(dst)
  );

  atm_match_table #(.N_APP(N_APP), .ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .key(key), .dst(dst), .route(raw_rt)
  );

  always_comb begin
    full_v   = {app_full, mac_full};
    inc[0]   = decide && (raw_rt == RT_MAC) && full_v[0];
    inc[1]   = decide && (raw_rt == RT_APP) && full_v[1];
    final_rt = (inc[0] || inc[1]) ? RT_DROP : raw_rt;
    push_ent = '{sop: in_sop, cid: cid, data: in_data};
  end

  atm_replay_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(acc), .push_ent(push_ent),
    .set_pend(acc && in_sop), .pend_cid(cid),
    .set_route(decide), .route_cid(cid), .route_val(final_rt),
    .mac_wr_en(mac_wr_en), .app_wr_en(app_wr_en),
    .wr_sop(wr_sop), .wr_data(wr_data)
  );

  for (genvar q = 0; q < 2; q++) begin : g_ovf
    always_comb begin
      ovf_d[q] = ovf_q[q];
      if (inc[q] && ovf_q[q] != '1) ovf_d[q] = ovf_q[q] + CNT_W'(1);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_q[q] <= '0;
      else        ovf_q[q] <= ovf_d[q];
    end

    // R9: an overflow counter only ever steps up by exactly one
    a_r9_ovf_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q[q] != $past(ovf_q[q])) |-> (ovf_q[q] == $past(ovf_q[q]) + CNT_W'(1)));
  end

  assign mac_ovf_cnt = ovf_q[0];
  assign app_ovf_cnt = ovf_q[1];
  assign mac_wr_sop  = wr_sop;
  assign mac_wr_data = wr_data;
  assign app_wr_sop  = wr_sop;
  assign app_wr_data = wr_data;
  assign wr_en_v     = {app_wr_en, mac_wr_en};

  // R8: an unmatched cell leaves both counters alone
  a_r8_nomatch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && raw_rt == RT_DROP) |=> ($stable(ovf_q[0]) && $stable(ovf_q[1])));

  // R4 (MAC port) and R6 (application port): cells leave whole, 53 bytes each
  logic [SEEN_W-1:0] seen_q [2];
  logic [SEEN_W-1:0] seen_d [2];
  for (genvar p = 0; p < 2; p++) begin : g_seen
    always_comb begin
      seen_d[p] = seen_q[p];
      if (wr_en_v[p]) seen_d[p] = wr_sop ? SEEN_W'(1) : seen_q[p] + SEEN_W'(1);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q[p] <= '0;
      else        seen_q[p] <= seen_d[p];
    end

    a_r4_cell_start: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_v[p] && wr_sop) |->
        (seen_q[p] == '0 || seen_q[p] == SEEN_W'(CELL_BYTES)));

    a_r4_cell_body: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_v[p] && !wr_sop) |->
        (seen_q[p] != '0 && seen_q[p] < SEEN_W'(CELL_BYTES)));
  end

endmodule

// File: tb/atm_cell_filter_tb.sv
module atm_cell_filter_tb;

  localparam int N_APP = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sop, in_ok;
  logic [7:0]  in_data;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [24:0] cfg_wdata;
  logic        mac_full, app_full;
  logic        mac_wr_en, mac_wr_sop, app_wr_en, app_wr_sop;
  logic [7:0]  mac_wr_data, app_wr_data, mac_ovf_cnt, app_ovf_cnt;

  atm_cell_filter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_ok(in_ok), .in_data(in_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mac_full(mac_full), .mac_wr_en(mac_wr_en),
    .mac_wr_sop(mac_wr_sop), .mac_wr_data(mac_wr_data),
    .mac_ovf_cnt(mac_ovf_cnt), .app_full(app_full), .app_wr_en(app_wr_en),
    .app_wr_sop(app_wr_sop), .app_wr_data(app_wr_data),
    .app_ovf_cnt(app_ovf_cnt)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cell_no = 0;
  int exp_mac_ovf = 0;
  int exp_app_ovf = 0;

  logic [8:0]  got_mac[$], got_app[$], exp_mac[$], exp_app[$];
  logic [24:0] m_ent[N_APP+1];
  logic [15:0] m_sta;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mac_wr_en) got_mac.push_back({mac_wr_sop, mac_wr_data});
      if (app_wr_en) got_app.push_back({app_wr_sop, app_wr_data});
    end
  end

  task automatic cfg_write(input int addr, input logic [24:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr <= N_APP) m_ent[addr] = d;
    else if (addr == N_APP + 1) m_sta = d[15:0];
  endtask

  // 0 drop, 1 MAC queue, 2 application queue
  function automatic int model_route(input logic [7:0] vpi, input logic [15:0] vci,
                                     input logic [15:0] dst);
    logic [23:0] k = {vpi, vci};
    if (m_ent[N_APP][24] && m_ent[N_APP][23:0] == k) return (dst == m_sta) ? 1 : 0;
    for (int i = 0; i < N_APP; i++)
      if (m_ent[i][24] && m_ent[i][23:0] == k) return 2;
    return 0;
  endfunction

  task automatic send_cell(input logic [7:0] vpi, input logic [15:0] vci,
                           input logic [15:0] dst, input bit ok, input int gap);
    logic [7:0] b[53];
    int rt;
    b[0] = {4'(cell_no), vpi[7:4]};
    b[1] = {vpi[3:0], vci[15:12]};
    b[2] = vci[11:4];
    b[3] = {vci[3:0], 4'(cell_no * 3)};
    b[4] = 8'(cell_no * 29 + 5);
    b[5] = dst[15:8];
    b[6] = dst[7:0];
    for (int k = 7; k < 53; k++) b[k] = 8'(cell_no * 7 + k * 13);
    rt = ok ? model_route(vpi, vci, dst) : 0;
    if (rt == 1 && mac_full) begin rt = 0; if (exp_mac_ovf < 255) exp_mac_ovf++; end
    if (rt == 2 && app_full) begin rt = 0; if (exp_app_ovf < 255) exp_app_ovf++; end
    for (int k = 0; k < 53; k++) begin
      if (rt == 1) exp_mac.push_back({k == 0, b[k]});
      if (rt == 2) exp_app.push_back({k == 0, b[k]});
    end
    for (int k = 0; k < 53; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (k == 0); in_ok = ok; in_data = b[k];
      if (gap > 0 && (k % gap) == gap - 1) begin
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0;
      end
    end
    cell_no++;
  endtask

  // scenario kinds used by the sweeps
  task automatic send_kind(input int sc, input int gap);
    case (sc)
      0: send_cell(8'h12, 16'h0345, 16'h1111, 1'b1, gap);  // app entry 0, nibble-split key
      1: send_cell(8'hA0, 16'hFFFF, 16'h2222, 1'b1, gap);  // app entry 1
      2: send_cell(8'h33, 16'h0033, 16'h3333, 1'b1, gap);  // entry 2 (disabled)
      3: send_cell(8'h00, 16'h0020, 16'hBEEF, 1'b1, gap);  // MAC, own station
      4: send_cell(8'h00, 16'h0020, 16'hBEEE, 1'b1, gap);  // MAC channel, other station
      5: send_cell(8'h12, 16'h0344, 16'h1111, 1'b1, gap);  // one bit from entry 0
      default: send_cell(8'h12, 16'h0345, 16'h1111, 1'b0, gap); // damaged cell
    endcase
  endtask

  task automatic drain_check(input string req);
    int bad;
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
    repeat (40) @(negedge clk);
    bad = (got_mac.size() != exp_mac.size()) ? 1 : 0;
    if (bad == 0) for (int i = 0; i < got_mac.size(); i++) if (got_mac[i] != exp_mac[i]) bad++;
    chk(bad == 0, {req, " MAC port bytes"}, got_mac.size(), exp_mac.size());
    bad = (got_app.size() != exp_app.size()) ? 1 : 0;
    if (bad == 0) for (int i = 0; i < got_app.size(); i++) if (got_app[i] != exp_app[i]) bad++;
    chk(bad == 0, {req, " application port bytes"}, got_app.size(), exp_app.size());
    chk(int'(mac_ovf_cnt) == exp_mac_ovf, {req, " MAC overflow count"}, mac_ovf_cnt, exp_mac_ovf);
    chk(int'(app_ovf_cnt) == exp_app_ovf, {req, " app overflow count"}, app_ovf_cnt, exp_app_ovf);
    got_mac.delete(); got_app.delete(); exp_mac.delete(); exp_app.delete();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_ok = 1'b0; in_data = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; mac_full = 1'b0; app_full = 1'b0;
    for (int i = 0; i <= N_APP; i++) m_ent[i] = '0;
    m_sta = '0;
    repeat (3) @(negedge clk);
    chk(!mac_wr_en && !app_wr_en, "R11 write enables in reset", mac_wr_en + app_wr_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mac_wr_en && !app_wr_en, "R11 write enables after reset", mac_wr_en + app_wr_en, 0);
    chk(mac_ovf_cnt == 0 && app_ovf_cnt == 0, "R11 counters after reset",
        mac_ovf_cnt + app_ovf_cnt, 0);

    // R3 and R7: with the reset table nothing matches, even the MAC key with station 0
    send_cell(8'h00, 16'h0000, 16'h0000, 1'b1, 0);
    send_cell(8'h12, 16'h0345, 16'h0000, 1'b1, 0);
    drain_check("R3 R7 reset table");

    cfg_write(0, {1'b1, 8'h12, 16'h0345});
    cfg_write(1, {1'b1, 8'hA0, 16'hFFFF});
    cfg_write(2, {1'b0, 8'h33, 16'h0033});
    cfg_write(3, {1'b1, 8'h00, 16'h0020});
    cfg_write(4, {1'b1, 8'h00, 16'h0020});
    cfg_write(5, {9'h0, 16'hBEEF});
    // R3: addresses 6 and 7 must not disturb any entry
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 3'd6; cfg_wdata = {1'b1, 8'h33, 16'h0033};
    @(negedge clk); cfg_addr = 3'd7; cfg_wdata = '1;
    @(negedge clk); cfg_we = 1'b0;

    // one cell at a time, each kind
    send_kind(0, 0); drain_check("R2 R6 entry 0 split key");
    send_kind(1, 0); drain_check("R6 entry 1");
    send_kind(2, 0); drain_check("R7 disabled entry, R3 unused addresses");
    send_kind(3, 0); drain_check("R4 MAC cell");
    send_kind(4, 0); drain_check("R5 MAC channel wrong station");
    send_kind(5, 0); drain_check("R8 near-miss key");
    send_kind(6, 0); drain_check("R1 damaged cell");

    // R10: all kinds back to back under several gap patterns
    for (int g = 0; g < 5; g++) begin
      for (int sc = 0; sc < 7; sc++) send_kind(sc, (g == 4) ? 2 : g * 3);
      drain_check("R10 back-to-back sweep");
    end

    // R10: stray bytes outside a cell are ignored
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); in_valid = 1'b1; in_sop = 1'b0; in_ok = 1'b1; in_data = 8'(k * 17);
    end
    send_kind(0, 1);
    drain_check("R10 stray bytes");

    // R3 R7: enable entry 2, disable entry 0
    cfg_write(2, {1'b1, 8'h33, 16'h0033});
    cfg_write(0, {1'b0, 8'h12, 16'h0345});
    send_kind(2, 0); send_kind(0, 0);
    drain_check("R3 R7 rewritten entries");

    // R9: full MAC queue drops the MAC cell, application cell still passes
    mac_full = 1'b1;
    send_kind(3, 0); send_kind(1, 0);
    drain_check("R9 MAC full");
    app_full = 1'b1;
    send_kind(5, 0); send_kind(4, 0);
    drain_check("R8 no-match with both full");
    mac_full = 1'b0;
    send_kind(3, 0);
    drain_check("R9 MAC room again");
    for (int n = 0; n < 258; n++) send_kind(1, 0);
    drain_check("R9 app counter saturation");
    app_full = 1'b0;
    send_kind(1, 0); send_kind(3, 0);
    drain_check("R9 after saturation");

    finish_run();
  end

endmodule